// File: doc/BRIEF.md
# Boolean Delta-Rule Perceptron Trainer

This block is a digital model of a single-layer perceptron array that trains itself. Each row is one neuron, and each row learns one Boolean function of `N_IN` inputs. Every input column holds its weight as two saturating counters, an excitatory one and an inhibitory one, and the weight is their difference. A bias column takes part in the sum as an input that is always +1.

After a start request, the trainer runs through epochs. Each epoch presents every truth-table entry once, in ascending order. For each entry the trainer evaluates every row's sign output and compares it with the row's target. Each row that gives the wrong answer then receives one programming step. The target sign picks which counter of each pair is addressed. The input level on the column picks whether that counter moves up or down. Rows with a negative target are stepped in a first pulse phase, and rows with a positive target in a second pulse phase. Training stops when a whole epoch needs no update, or when the epoch limit is reached.

The target table is a static configuration vector, and the status pins are plain levels. No stream interface is involved, so there is no back-pressure. Row results are qualified by a one-cycle strobe that the consumer cannot stall.

Top module: `pt_trainer`

## Requirements
- R1: After reset, `row_out`, `out_valid`, `busy`, `learned`, `fail` and `epoch_cnt` are all 0.
- R2: Each epoch presents entries 0 to 2^N_IN-1 in ascending order. For entry k, input i is +1 when bit i of k is 1 and −1 when it is 0. The bias column is always +1. During the strobe, `entry_idx` shows k.
- R3: `row_out[j]` is 1 (meaning +1) exactly when the sum over all columns of input × (excitatory − inhibitory) is strictly greater than zero. Otherwise it is 0 (meaning −1). All counters start at `G_OFF`, so the first outputs are all 0.
- R4: Target bit `target[j*2^N_IN+k]` gives row j's desired output for entry k, where 1 means +1. A row whose output matches its target has no counter changed for that entry.
- R5: A wrong row with target +1 changes only its excitatory counters. Each one steps by +1 where its column input is +1 and by −1 where it is −1.
- R6: A wrong row with target −1 changes only its inhibitory counters. Each one steps by +1 where its column input is +1 and by −1 where it is −1.
- R7: Counters saturate at 0 and at 2^W−1, and never wrap.
- R8: Each entry takes five clocks: present, evaluate, compare, negative pulse, positive pulse. `out_valid` is high for exactly the compare clock.
- R9: When an epoch ends with no row updated, `learned` rises, `busy` falls, and `epoch_cnt` equals the number of epochs run, counting that clean epoch.
- R10: When `MAX_EPOCH` epochs end without a clean one, `fail` rises and `busy` falls, with `epoch_cnt` equal to `MAX_EPOCH`. `learned` and `fail` are never high together.
- R11: `start` is ignored while `busy`. While idle, `start` reloads every counter to `G_OFF`, clears the flags and `epoch_cnt`, and begins epoch 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin training (honoured only when idle) |
| target | input | N_ROWS*2^N_IN | Desired output per row and entry, 1 = +1 |
| row_out | output | N_ROWS | Sign output per row, 1 = +1 |
| out_valid | output | 1 | High for the compare clock of each entry |
| entry_idx | output | N_IN | Truth-table entry being presented |
| busy | output | 1 | Training in progress |
| learned | output | 1 | Last run ended with a clean epoch |
| fail | output | 1 | Last run hit the epoch limit |
| epoch_cnt | output | $clog2(MAX_EPOCH+1) | Completed epochs in the current or last run |

## Verification
The bench builds the trainer with two inputs, sixteen rows, 4-bit counters starting at 8, and the default 64-epoch limit. With sixteen rows, every two-input Boolean function fits in one array at once. The two non-separable functions in that set force the epoch-limit path. The narrow counters let saturation at both ends occur within the limit. An arithmetic model of the counters predicts every row output of every entry, and the final flags and epoch count, for all-low, all-high, all-sixteen and separable-only target tables.

// File: rtl/pt_pkg.sv
package pt_pkg;
  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_PRESENT = 3'd1,
    PH_EVAL    = 3'd2,
    PH_COMPARE = 3'd3,
    PH_NEG     = 3'd4,
    PH_POS     = 3'd5
  } phase_t;
endpackage

// File: rtl/pt_synapse.sv
module pt_synapse #(
  parameter int W     = 8,
  parameter int G_OFF = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         init,
  input  logic         step_en,
  input  logic         step_up,
  output logic [W-1:0] g
);
  localparam logic [W-1:0] GMAX  = '1;
  localparam logic [W-1:0] GINIT = W'(G_OFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      g <= GINIT;
    end else if (init) begin
      g <= GINIT;
    end else if (step_en) begin
      if (step_up && g != GMAX) g <= g + 1'b1;
      else if (!step_up && g != '0) g <= g - 1'b1;
    end
  end

  // R7: no wrap at either end
  p_sat_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!init && step_en && step_up && g == GMAX) |=> (g == GMAX));
  p_sat_bot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!init && step_en && !step_up && g == '0) |=> (g == '0));
  // R5/R6: one step moves a counter by at most one
  p_unit_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!init) |=> (g == $past(g) || g == $past(g) + 1'b1 || g == $past(g) - 1'b1));
endmodule

// File: rtl/pt_row.sv
module pt_row
  import pt_pkg::*;
#(
  parameter int N_COL = 3,
  parameter int W     = 8,
  parameter int G_OFF = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  phase_t           phase,
  input  logic [N_COL-1:0] x_pos,
  input  logic             y,
  output logic             out_bit,
  output logic             err
);
  localparam int SUMW = W + 2 + $clog2(N_COL + 1);

  logic [N_COL-1:0][W-1:0] gp;
  logic [N_COL-1:0][W-1:0] gn;
  logic                    pos_step;
  logic                    neg_step;
  logic signed [SUMW-1:0]  acc;
  logic signed [SUMW-1:0]  wv;
  logic                    above_zero;

  assign pos_step = (phase == PH_POS) && err && y;
  assign neg_step = (phase == PH_NEG) && err && !y;

  for (genvar c = 0; c < N_COL; c++) begin : g_col
    pt_synapse #(.W(W), .G_OFF(G_OFF)) u_exc (
      .clk(clk), .rst_n(rst_n), .init(init),
      .step_en(pos_step), .step_up(x_pos[c]), .g(gp[c])
    );
    pt_synapse #(.W(W), .G_OFF(G_OFF)) u_inh (
      .clk(clk), .rst_n(rst_n), .init(init),
      .step_en(neg_step), .step_up(x_pos[c]), .g(gn[c])
    );
  end

  always_comb begin
    acc = '0;
    wv  = '0;
    for (int c = 0; c < N_COL; c++) begin
      wv  = $signed({{(SUMW-W){1'b0}}, gp[c]}) - $signed({{(SUMW-W){1'b0}}, gn[c]});
      acc = x_pos[c] ? (acc + wv) : (acc - wv);
    end
  end

  assign above_zero = !acc[SUMW-1] && (acc != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_bit <= 1'b0;
      err     <= 1'b0;
    end else if (init) begin
      out_bit <= 1'b0;
      err     <= 1'b0;
    end else begin
      if (phase == PH_EVAL)    out_bit <= above_zero;
      if (phase == PH_COMPARE) err     <= out_bit ^ y;
    end
  end

  // R4: a correct row keeps all counters during the pulse phases
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase == PH_NEG || phase == PH_POS) && !err) |=> ($stable(gp) && $stable(gn)));
  // R6: the negative pulse never touches excitatory counters
  p_neg_side_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_NEG) |=> $stable(gp));
  // R5: the positive pulse never touches inhibitory counters
  p_pos_side_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_POS) |=> $stable(gn));
endmodule

// File: rtl/pt_seq.sv
module pt_seq
  import pt_pkg::*;
#(
  parameter int N_IN      = 2,
  parameter int N_ROWS    = 8,
  parameter int MAX_EPOCH = 64,
  parameter int EPW       = $clog2(MAX_EPOCH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [N_ROWS-1:0] row_err,
  output phase_t          phase,
  output logic [N_IN-1:0] entry,
  output logic [N_IN:0]   x_vec,
  output logic            init,
  output logic            busy,
  output logic            out_valid,
  output logic            learned,
  output logic            fail,
  output logic [EPW-1:0]  epoch_cnt
);
  localparam logic [N_IN-1:0] LAST = '1;
  localparam logic [EPW-1:0]  EMAX = EPW'(MAX_EPOCH);

  logic           dirty;
  logic           dirty_now;
  logic [EPW-1:0] epoch_nxt;

  assign init      = (phase == PH_IDLE) && start;
  assign busy      = (phase != PH_IDLE);
  assign out_valid = (phase == PH_COMPARE);
  assign dirty_now = dirty || (|row_err);
  assign epoch_nxt = epoch_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      entry     <= '0;
      x_vec     <= '0;
      dirty     <= 1'b0;
      learned   <= 1'b0;
      fail      <= 1'b0;
      epoch_cnt <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (start) begin
          phase     <= PH_PRESENT;
          entry     <= '0;
          dirty     <= 1'b0;
          learned   <= 1'b0;
          fail      <= 1'b0;
          epoch_cnt <= '0;
        end
        PH_PRESENT: begin
          x_vec <= {1'b1, entry};
          phase <= PH_EVAL;
        end
        PH_EVAL:    phase <= PH_COMPARE;
        PH_COMPARE: phase <= PH_NEG;
        PH_NEG:     phase <= PH_POS;
        PH_POS: begin
          if (entry == LAST) begin
            epoch_cnt <= epoch_nxt;
            entry     <= '0;
            dirty     <= 1'b0;
            if (!dirty_now) begin
              learned <= 1'b1;
              phase   <= PH_IDLE;
            end else if (epoch_nxt == EMAX) begin
              fail  <= 1'b1;
              phase <= PH_IDLE;
            end else begin
              phase <= PH_PRESENT;
            end
          end else begin
            entry <= entry + 1'b1;
            dirty <= dirty_now;
            phase <= PH_PRESENT;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R10: outcomes are exclusive and the count never passes the limit
  p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n) !(learned && fail));
  p_cap_r10: assert property (@(posedge clk) disable iff (!rst_n) epoch_cnt <= EMAX);
  // R8: the result strobe lasts a single clock
  p_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n) out_valid |=> !out_valid);
  // R11: while training the epoch count never falls back
  p_nostart_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (epoch_cnt >= $past(epoch_cnt)));
  // R9: a learned outcome only appears once training has stopped
  p_done_r9: assert property (@(posedge clk) disable iff (!rst_n) $rose(learned) |-> !busy);
endmodule

// File: rtl/pt_trainer.sv
module pt_trainer
  import pt_pkg::*;
#(
  parameter int N_IN      = 2,
  parameter int N_ROWS    = 8,
  parameter int W         = 8,
  parameter int G_OFF     = 16,
  parameter int MAX_EPOCH = 64
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             start,
  input  logic [N_ROWS*(2**N_IN)-1:0]      target,
  output logic [N_ROWS-1:0]                row_out,
  output logic                             out_valid,
  output logic [N_IN-1:0]                  entry_idx,
  output logic                             busy,
  output logic                             learned,
  output logic                             fail,
  output logic [$clog2(MAX_EPOCH+1)-1:0]   epoch_cnt
);
  localparam int N_ENT = 2 ** N_IN;
  localparam int N_COL = N_IN + 1;
  localparam int EPW   = $clog2(MAX_EPOCH + 1);

  phase_t              phase;
  logic [N_IN-1:0]     entry;
  logic [N_IN:0]       x_vec;
  logic                init;
  logic [N_ROWS-1:0]   row_err;
  logic [N_ROWS-1:0]   y_vec;

  pt_seq #(
    .N_IN(N_IN), .N_ROWS(N_ROWS), .MAX_EPOCH(MAX_EPOCH), .EPW(EPW)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .row_err(row_err),
    .phase(phase), .entry(entry), .x_vec(x_vec), .init(init),
    .busy(busy), .out_valid(out_valid), .learned(learned),
    .fail(fail), .epoch_cnt(epoch_cnt)
  );

  for (genvar j = 0; j < N_ROWS; j++) begin : g_row
    assign y_vec[j] = target[j*N_ENT + int'(entry)];

    pt_row #(.N_COL(N_COL), .W(W), .G_OFF(G_OFF)) u_row (
      .clk(clk), .rst_n(rst_n), .init(init), .phase(phase),
      .x_pos(x_vec), .y(y_vec[j]),
      .out_bit(row_out[j]), .err(row_err[j])
    );
  end

  assign entry_idx = entry;

  // R2: the bias column is +1 whenever a result is reported
  p_bias_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (x_vec[N_IN] && x_vec[N_IN-1:0] == entry_idx));
endmodule

// File: tb/test_pt_trainer.sv
module test_pt_trainer;
  localparam int N_IN = 2, N_ROWS = 16, W = 4, G_OFF = 8, MAX_EPOCH = 64;
  localparam int N_ENT = 4, N_COL = 3, GMAX = 15;

  logic clk = 0, rst_n = 0, start = 0;
  logic [N_ROWS*N_ENT-1:0] target = '0;
  logic [N_ROWS-1:0] row_out;
  logic out_valid, busy, learned, fail;
  logic [N_IN-1:0] entry_idx;
  logic [6:0] epoch_cnt;

  int n_chk = 0, n_bad = 0;
  bit wd_hit = 0;
  int gp [N_ROWS][N_COL];
  int gn [N_ROWS][N_COL];

  always #5 clk = ~clk;

  pt_trainer #(.N_IN(N_IN), .N_ROWS(N_ROWS), .W(W), .G_OFF(G_OFF),
               .MAX_EPOCH(MAX_EPOCH)) i_pt_trainer (
    .clk(clk), .rst_n(rst_n), .start(start), .target(target),
    .row_out(row_out), .out_valid(out_valid), .entry_idx(entry_idx),
    .busy(busy), .learned(learned), .fail(fail), .epoch_cnt(epoch_cnt)
  );

  initial begin
    repeat (150000) @(posedge clk);
    wd_hit = 1;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int sat(input int v);
    if (v > GMAX) return GMAX;
    if (v < 0) return 0;
    return v;
  endfunction

  function automatic int xval(input int k, input int c);
    if (c == N_IN) return 1;
    return ((k >> c) & 1) ? 1 : -1;
  endfunction

  // one training run; expected values from an arithmetic model of R2..R10
  task automatic do_run(input logic [N_ROWS*N_ENT-1:0] tg, input bit poke, input string tag);
    int ep_done;
    bit exp_learn;
    target = tg;
    for (int j = 0; j < N_ROWS; j++)
      for (int c = 0; c < N_COL; c++) begin gp[j][c] = G_OFF; gn[j][c] = G_OFF; end
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    chk(busy == 1'b1, {"R11 busy after start ", tag}, busy, 1);
    ep_done = 0; exp_learn = 0;
    for (int e = 0; e < MAX_EPOCH; e++) begin
      bit dirty = 0;
      for (int k = 0; k < N_ENT; k++) begin
        logic [N_ROWS-1:0] exp_out;
        for (int j = 0; j < N_ROWS; j++) begin
          int s = 0;
          for (int c = 0; c < N_COL; c++) s += xval(k, c) * (gp[j][c] - gn[j][c]);
          exp_out[j] = (s > 0);
        end
        while (!out_valid && !wd_hit) @(negedge clk);
        chk(entry_idx == N_IN'(k), {"R2 entry order ", tag}, entry_idx, k);
        chk(row_out == exp_out, {"R3 R5 R6 R7 row outputs ", tag}, row_out, exp_out);
        if (poke && e == 1 && k == 0) start = 1;
        @(negedge clk);
        start = 0;
        chk(out_valid == 1'b0, {"R8 strobe width ", tag}, out_valid, 0);
        for (int j = 0; j < N_ROWS; j++) begin
          bit y = tg[j*N_ENT + k];
          if (exp_out[j] != y) begin
            dirty = 1;
            for (int c = 0; c < N_COL; c++)
              if (y) gp[j][c] = sat(gp[j][c] + xval(k, c));
              else   gn[j][c] = sat(gn[j][c] + xval(k, c));
          end
        end
      end
      ep_done = e + 1;
      if (!dirty) begin exp_learn = 1; break; end
    end
    while (busy && !wd_hit) @(negedge clk);
    chk(learned == exp_learn, {"R9 learned ", tag}, learned, exp_learn);
    chk(fail == !exp_learn, {"R10 fail ", tag}, fail, !exp_learn);
    chk(epoch_cnt == 7'(ep_done), {"R9 R10 epoch count ", tag}, epoch_cnt, ep_done);
  endtask

  initial begin
    logic [N_ROWS*N_ENT-1:0] all_fn, sep_fn;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(row_out == '0 && out_valid == 0, "R1 outputs", {row_out, out_valid}, 0);
    chk(busy == 0 && learned == 0 && fail == 0, "R1 flags", {busy, learned, fail}, 0);
    chk(epoch_cnt == 0, "R1 epoch count", epoch_cnt, 0);
    rst_n = 1;
    @(negedge clk);
    for (int j = 0; j < N_ROWS; j++) all_fn[j*N_ENT +: N_ENT] = 4'(j);
    sep_fn = all_fn;
    sep_fn[6*N_ENT +: N_ENT] = 4'b1000;
    sep_fn[9*N_ENT +: N_ENT] = 4'b0111;
    do_run('0, 0, "all-low");                 // R4 clean first epoch
    do_run('1, 0, "all-high");
    do_run(all_fn, 1, "all-sixteen");         // R11 start while busy, R10 limit
    do_run(sep_fn, 0, "separable");           // R11 restart reloads counters
    // R11: start while idle after a run clears the outcome
    @(negedge clk); start = 1; target = '0;
    @(negedge clk); start = 0;
    chk(learned == 0 && fail == 0 && epoch_cnt == 0, "R11 restart clears",
        {learned, fail, epoch_cnt}, 0);
    while (busy && !wd_hit) @(negedge clk);
    if (wd_hit) chk(0, "watchdog", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule